// File: doc/BRIEF.md
# Sprite pixel priority multiplexer

This block composes the final pixel for one scanline from up to eight sprites and the background. Each sprite slot holds a horizontal-position down-counter, a small attribute field and two pattern shift registers, one per colour bit plane. All slots are loaded together by a single strobe before the line begins. After that, every enabled dot counts the counters down. When a slot's counter has reached zero, the slot presents one pattern pixel per enabled dot, MSB first, and stops after eight pixels.

Every enabled dot, the block takes the lowest-numbered slot that shows an opaque pixel. It then decides between that pixel and the background pixel using the slot's behind-background bit. Slots with a higher index are ignored once an opaque pixel has been found. This holds even when the chosen sprite ends up hidden behind an opaque background, so a sprite drawn behind the background can mask sprites of lower priority. The result is registered and carries a flag bit that marks sprite-sourced pixels.

Top module: `sprite_pixel_mux`

## Requirements
- R1: After reset `pix_o` is 0, and until the first load every enabled dot outputs `{1'b0, bg_pix_i}`.
- R2: While `load_i` is high, slot s captures its X position, its attribute field and both pattern bytes. A slot loaded with `spr_valid_i[s]` low holds a transparent bitmap and never affects `pix_o`.
- R3: Enabled dots are numbered d = 0, 1, … after a load. Slot s shows pattern pixel k = d − X at dot d, for k from 0 to 7. Its 2-bit colour is `{pat_hi[7-k], pat_lo[7-k]}`, and colour 0 is transparent.
- R4: A slot shows nothing after its eighth pixel until it is loaded again.
- R5: While `dot_en_i` is low, the counters, the shifters and `pix_o` hold their values.
- R6: Among the slots with an opaque pixel on a dot, the lowest slot index is selected.
- R7: If no slot is opaque, `pix_o` = `{1'b0, bg_pix_i}`. Background bits [3:2] are the palette and bits [1:0] the colour, with colour 0 transparent.
- R8: If the selected slot has attribute bit 2 at 0 (in front), `pix_o` = `{1'b1, attr[1:0], colour}`.
- R9: If the selected slot has attribute bit 2 at 1 (behind), `pix_o` is `{1'b0, bg_pix_i}` when the background colour is nonzero. Otherwise it is the sprite pixel as in R8.
- R10: A behind slot that is selected hides every higher-index slot, including in-front opaque ones, so the output becomes the opaque background.
- R11: `pix_o` is registered. It changes at the clock edge that ends an enabled dot, and it shows that dot's composition using that cycle's `bg_pix_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Dot clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Loads all slots for the coming line |
| spr_valid_i | input | NUM_SPR | Per-slot valid; low loads a transparent bitmap |
| spr_x_i | input | NUM_SPR*XPOS_W | Per-slot X position |
| spr_attr_i | input | NUM_SPR*3 | Per-slot {behind, palette[1:0]} |
| spr_pat_lo_i | input | NUM_SPR*PAT_W | Per-slot pattern bit plane 0 |
| spr_pat_hi_i | input | NUM_SPR*PAT_W | Per-slot pattern bit plane 1 |
| dot_en_i | input | 1 | Advances one dot |
| bg_pix_i | input | 4 | Background pixel {palette, colour} |
| pix_o | output | 5 | Final pixel {sprite flag, palette, colour} |

## Verification
A counter that is off by one, or a shifter that keeps running, moves a sprite horizontally. The error appears at `pix_o` on the first enabled dot where the sprite's edge lands, so it is caught one cycle after that dot. A wrong priority order or a wrong combine decision shows up on the first dot where two opaque sources overlap. The stimulus therefore places overlapping slots with mixed behind bits on top of both opaque and transparent backgrounds. A slot that lost its valid flag, or a sprite that runs past eight pixels, leaves stray sprite pixels next to bare background, and these are checked on every dot.

// File: rtl/spr_mux_pkg.sv
package spr_mux_pkg;
  typedef struct packed {
    logic [1:0] pal;
    logic       behind;
    logic [1:0] color;
  } spr_pix_t;

  localparam int unsigned ATTR_FW = 3;
  localparam int unsigned BEHIND_BIT = 2;
endpackage

// File: rtl/sprite_slot.sv
module sprite_slot
  import spr_mux_pkg::*;
#(
  parameter int unsigned XPOS_W = 8,
  parameter int unsigned PAT_W  = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic                valid_i,
  input  logic [XPOS_W-1:0]   x_i,
  input  logic [ATTR_FW-1:0]  attr_i,
  input  logic [PAT_W-1:0]    pat_lo_i,
  input  logic [PAT_W-1:0]    pat_hi_i,
  input  logic                dot_en_i,
  output spr_pix_t            pix_o
);
  localparam int unsigned REM_W = $clog2(PAT_W + 1);

  logic [XPOS_W-1:0]  x_cnt_q;
  logic [1:0]         pal_q;
  logic               behind_q;
  logic [PAT_W-1:0]   lo_q, hi_q;
  logic [REM_W-1:0]   rem_q;
  logic               active;

  assign active = (x_cnt_q == '0) && (rem_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_cnt_q  <= '0;
      pal_q    <= '0;
      behind_q <= 1'b0;
      lo_q     <= '0;
      hi_q     <= '0;
      rem_q    <= '0;
    end else if (load_i) begin
      x_cnt_q  <= x_i;
      pal_q    <= attr_i[1:0];
      behind_q <= attr_i[BEHIND_BIT];
      lo_q     <= valid_i ? pat_lo_i : '0;
      hi_q     <= valid_i ? pat_hi_i : '0;
      rem_q    <= valid_i ? REM_W'(PAT_W) : '0;
    end else if (dot_en_i) begin
      if (x_cnt_q != '0) begin
        x_cnt_q <= x_cnt_q - XPOS_W'(1);
      end else if (rem_q != '0) begin
        lo_q  <= {lo_q[PAT_W-2:0], 1'b0};
        hi_q  <= {hi_q[PAT_W-2:0], 1'b0};
        rem_q <= rem_q - REM_W'(1);
      end
    end
  end

  always_comb begin
    pix_o.pal    = pal_q;
    pix_o.behind = behind_q;
    pix_o.color  = active ? {hi_q[PAT_W-1], lo_q[PAT_W-1]} : 2'b00;
  end
endmodule

// File: rtl/sprite_prio_sel.sv
module sprite_prio_sel
  import spr_mux_pkg::*;
#(
  parameter int unsigned NUM_SPR = 8
) (
  input  spr_pix_t             pix_i [NUM_SPR],
  output logic                 hit_o,
  output spr_pix_t             sel_o,
  output logic [NUM_SPR-1:0]   grant_o
);
  // lowest index wins
  always_comb begin
    hit_o   = 1'b0;
    sel_o   = '0;
    grant_o = '0;
    for (int i = 0; i < NUM_SPR; i++) begin
      if (!hit_o && (pix_i[i].color != 2'b00)) begin
        hit_o      = 1'b1;
        sel_o      = pix_i[i];
        grant_o[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pixel_compose.sv
module pixel_compose
  import spr_mux_pkg::*;
(
  input  logic       hit_i,
  input  spr_pix_t   sel_i,
  input  logic [3:0] bg_i,
  output logic [4:0] pix_o
);
  logic bg_opaque;
  assign bg_opaque = (bg_i[1:0] != 2'b00);

  always_comb begin
    if (!hit_i || (sel_i.behind && bg_opaque)) pix_o = {1'b0, bg_i};
    else                                       pix_o = {1'b1, sel_i.pal, sel_i.color};
  end
endmodule

// File: rtl/sprite_pixel_mux.sv
module sprite_pixel_mux
  import spr_mux_pkg::*;
#(
  parameter int unsigned NUM_SPR = 8,
  parameter int unsigned XPOS_W  = 8,
  parameter int unsigned PAT_W   = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          load_i,
  input  logic [NUM_SPR-1:0]            spr_valid_i,
  input  logic [NUM_SPR*XPOS_W-1:0]     spr_x_i,
  input  logic [NUM_SPR*ATTR_FW-1:0]    spr_attr_i,
  input  logic [NUM_SPR*PAT_W-1:0]      spr_pat_lo_i,
  input  logic [NUM_SPR*PAT_W-1:0]      spr_pat_hi_i,
  input  logic                          dot_en_i,
  input  logic [3:0]                    bg_pix_i,
  output logic [4:0]                    pix_o
);
  spr_pix_t             slot_pix [NUM_SPR];
  spr_pix_t             sel_pix;
  logic                 sel_hit;
  logic [NUM_SPR-1:0]   grant;
  logic [4:0]           pix_d;
  logic [4:0]           pix_q;

  for (genvar s = 0; s < NUM_SPR; s++) begin : g_slot
    sprite_slot #(
      .XPOS_W (XPOS_W),
      .PAT_W  (PAT_W)
    ) u_slot (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load_i   (load_i),
      .valid_i  (spr_valid_i[s]),
      .x_i      (spr_x_i[s*XPOS_W +: XPOS_W]),
      .attr_i   (spr_attr_i[s*ATTR_FW +: ATTR_FW]),
      .pat_lo_i (spr_pat_lo_i[s*PAT_W +: PAT_W]),
      .pat_hi_i (spr_pat_hi_i[s*PAT_W +: PAT_W]),
      .dot_en_i (dot_en_i),
      .pix_o    (slot_pix[s])
    );
  end

  sprite_prio_sel #(.NUM_SPR(NUM_SPR)) u_sel (
    .pix_i   (slot_pix),
    .hit_o   (sel_hit),
    .sel_o   (sel_pix),
    .grant_o (grant)
  );

  pixel_compose u_comp (
    .hit_i (sel_hit),
    .sel_i (sel_pix),
    .bg_i  (bg_pix_i),
    .pix_o (pix_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pix_q <= '0;
    else if (dot_en_i) pix_q <= pix_d;
  end

  assign pix_o = pix_q;
endmodule

// File: rtl/sprite_pixel_mux_chk.sv
module sprite_pixel_mux_chk #(
  parameter int unsigned NUM_SPR = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               dot_en_i,
  input logic [3:0]         bg_pix_i,
  input logic [4:0]         pix_o,
  input logic               sel_hit_i,
  input logic               sel_behind_i,
  input logic [NUM_SPR-1:0] grant_i
);
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dot_en_i |=> $stable(pix_o)); // R5

  AST_BG_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dot_en_i && !sel_hit_i) |=> (pix_o == {1'b0, $past(bg_pix_i)})); // R7

  AST_BEHIND_BG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dot_en_i && sel_hit_i && sel_behind_i && (bg_pix_i[1:0] != 2'b00))
      |=> (pix_o == {1'b0, $past(bg_pix_i)})); // R9

  AST_FRONT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dot_en_i && sel_hit_i && !sel_behind_i) |=> pix_o[4]); // R8

  AST_SPR_OPAQUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_o[4] |-> (pix_o[1:0] != 2'b00)); // R8

  AST_ONE_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_i)); // R6
endmodule

bind sprite_pixel_mux sprite_pixel_mux_chk #(.NUM_SPR(NUM_SPR)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .dot_en_i     (dot_en_i),
  .bg_pix_i     (bg_pix_i),
  .pix_o        (pix_o),
  .sel_hit_i    (sel_hit),
  .sel_behind_i (sel_pix.behind),
  .grant_i      (grant)
);

// File: tb/sprite_pixel_mux_tb_top.sv
`timescale 1ns/1ps
module sprite_pixel_mux_tb_top;
  localparam int NS = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic            load = 1'b0;
  logic            en = 1'b0;
  logic [NS-1:0]   valid = '0;
  logic [NS*8-1:0] xv = '0, lov = '0, hiv = '0;
  logic [NS*3-1:0] attrv = '0;
  logic [3:0]      bg = '0;
  logic [4:0]      pix;

  int         m_x [NS];
  logic [2:0] m_attr [NS];
  logic [7:0] m_lo [NS], m_hi [NS];
  logic       m_v [NS];
  int         d;
  logic [4:0] exp_q;
  int         n_chk = 0, n_fail = 0;

  sprite_pixel_mux dut_i (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .spr_valid_i(valid),
    .spr_x_i(xv), .spr_attr_i(attrv), .spr_pat_lo_i(lov), .spr_pat_hi_i(hiv),
    .dot_en_i(en), .bg_pix_i(bg), .pix_o(pix)
  );

  function automatic logic [4:0] model(input logic [3:0] b, output string tag);
    logic [NS-1:0] op;
    logic [1:0]    c [NS];
    int            sel;
    logic          front_below;
    sel = -1;
    front_below = 1'b0;
    for (int s = 0; s < NS; s++) begin
      c[s] = 2'b00;
      if (m_v[s] && d >= m_x[s] && (d - m_x[s]) < 8)
        c[s] = {m_hi[s][7-(d-m_x[s])], m_lo[s][7-(d-m_x[s])]};
      op[s] = (c[s] != 2'b00);
      if (op[s] && sel < 0) sel = s;
    end
    if (sel < 0) begin tag = "R7"; return {1'b0, b}; end
    for (int s = sel + 1; s < NS; s++)
      if (op[s] && !m_attr[s][2]) front_below = 1'b1;
    if (m_attr[sel][2]) begin
      if (b[1:0] != 2'b00) begin
        tag = front_below ? "R10" : "R9";
        return {1'b0, b};
      end
      tag = "R9";
      return {1'b1, m_attr[sel][1:0], c[sel]};
    end
    tag = ($countones(op) > 1) ? "R6" : "R8";
    return {1'b1, m_attr[sel][1:0], c[sel]};
  endfunction

  task automatic chk(input logic [4:0] act, input logic [4:0] e, input string tag);
    n_chk++;
    if (act !== e) begin
      n_fail++;
      $display("FAIL %s: pix_o=%b expected %b (dot %0d)", tag, act, e, d);
    end
  endtask

  task automatic step(input logic en_v, input logic [3:0] bg_v, input string ovr);
    string      tag;
    logic [4:0] e;
    en = en_v;
    bg = bg_v;
    if (en_v) begin e = model(bg_v, tag); d++; end
    else begin e = exp_q; tag = "R5"; end
    if (ovr != "") tag = ovr;
    @(posedge clk);
    @(negedge clk);
    chk(pix, e, tag);
    exp_q = e;
  endtask

  task automatic set_slot(input int s, input logic v, input int x, input logic [2:0] a,
                          input logic [7:0] lo, input logic [7:0] hi);
    m_v[s] = v; m_x[s] = x; m_attr[s] = a; m_lo[s] = lo; m_hi[s] = hi;
  endtask

  task automatic clear_slots();
    for (int s = 0; s < NS; s++) set_slot(s, 1'b0, 0, 3'b000, 8'h00, 8'h00);
  endtask

  task automatic do_load();
    for (int s = 0; s < NS; s++) begin
      valid[s]        = m_v[s];
      xv[s*8 +: 8]    = m_x[s][7:0];
      attrv[s*3 +: 3] = m_attr[s];
      lov[s*8 +: 8]   = m_lo[s];
      hiv[s*8 +: 8]   = m_hi[s];
    end
    en = 1'b0;
    load = 1'b1;
    @(posedge clk);
    @(negedge clk);
    load = 1'b0;
    chk(pix, exp_q, "R5");
    d = 0;
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL R11 watchdog: run not complete, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    d = 0;
    exp_q = '0;
    clear_slots();
    repeat (3) @(negedge clk);
    chk(pix, 5'd0, "R1");
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 4; i++) step(1'b1, 4'(i * 5 + 1), "R1");

    // position and length: slot 0 at X=3, opaque first and last pixel
    clear_slots();
    set_slot(0, 1'b1, 3, 3'b010, 8'b1000_0001, 8'b0000_0001);
    do_load();
    for (int i = 0; i < 14; i++)
      step(1'b1, 4'b0000, (i == 3) ? "R11" : ((i > 10) ? "R4" : "R3"));

    // invalid slots stay transparent
    clear_slots();
    set_slot(0, 1'b0, 0, 3'b001, 8'hFF, 8'hFF);
    set_slot(3, 1'b0, 2, 3'b011, 8'hFF, 8'h00);
    do_load();
    for (int i = 0; i < 10; i++) step(1'b1, 4'b1001, "R2");

    // hold while disabled mid-sprite
    clear_slots();
    set_slot(1, 1'b1, 1, 3'b001, 8'b1010_1100, 8'b0110_0101);
    do_load();
    for (int i = 0; i < 16; i++) step((i % 3) != 1, 4'b0100, "");

    // behind sprite hides in-front lower-priority sprite
    clear_slots();
    set_slot(0, 1'b1, 0, 3'b101, 8'hFF, 8'h00);
    set_slot(1, 1'b1, 0, 3'b010, 8'hFF, 8'hFF);
    do_load();
    step(1'b1, 4'b0110, "R10");
    step(1'b1, 4'b0100, "R9");
    step(1'b1, 4'b1101, "R10");
    step(1'b1, 4'b0000, "R9");

    // overlap of two front slots with gaps in the higher one
    clear_slots();
    set_slot(2, 1'b1, 0, 3'b001, 8'b1100_1100, 8'b0000_0000);
    set_slot(5, 1'b1, 0, 3'b011, 8'hFF, 8'hFF);
    do_load();
    for (int i = 0; i < 8; i++) step(1'b1, 4'b0011, "R6");

    // random lines
    for (int ln = 0; ln < 40; ln++) begin
      for (int s = 0; s < NS; s++)
        set_slot(s, ($urandom % 4) != 0, $urandom % 24, 3'($urandom),
                 8'($urandom), 8'($urandom));
      do_load();
      for (int i = 0; i < 36; i++) step(($urandom % 4) != 0, 4'($urandom), "");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule